// File: doc/BRIEF.md
# Load/Store Data Memory Access Unit

This unit sits between the execute stage of a small 32-bit processor core and a byte-addressed data memory that answers in one clock cycle. For each request it forms an effective address from a base value. The base may be used alone, with an immediate added, or with a second register value added. The unit then checks that the address suits the access width, which can be 8, 16 or 32 bits. A legal request becomes exactly one bus cycle, carrying the byte address, per-lane byte enables and, for stores, write data moved into the addressed lanes.

One cycle after the request, the unit returns a response valid strobe and a fault flag. For loads it also returns the addressed bytes, shifted down to bit 0 and zero-extended. Byte order is little-endian: the least significant byte of a multi-byte value lives at the lowest address. A misaligned or malformed request raises the fault flag, returns zero data and never reaches the memory bus, so memory is left untouched.

Top module: `lsu_core`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rsp_valid`, `mem_en`, `mem_we` and `req_ready` are low and `mem_be` is zero. From the second clock edge after release, `req_ready` stays high.
- R2: The effective address is selected by `req_mode`: 0 gives `req_base`; 1 gives `req_base + req_imm`; 2 gives `req_base + req_offreg`. The sum wraps modulo 2^32. Mode 3 is reserved and faults.
- R3: The access width is selected by `req_size`: 0 is a byte, 1 is a halfword, 2 is a word. Size code 3 is reserved and faults.
- R4: A halfword request at an odd effective address faults, and no bus cycle is produced. A later load of those bytes returns their earlier contents.
- R5: A word request whose effective address is not a multiple of 4 faults, and no bus cycle is produced.
- R6: During a bus cycle, `mem_addr` carries the full effective byte address. `mem_be` bit n enables byte lane n, meaning data bits 8n+7..8n. A byte enables lane addr[1:0]. A halfword enables 4'b0011 when addr[1] is 0 and 4'b1100 when addr[1] is 1. A word enables 4'b1111.
- R7: On a store, byte k of `req_wdata` is driven in lane addr[1:0]+k, for k below the access width in bytes. All other lanes of `mem_wdata` are zero, which gives little-endian placement.
- R8: On a load, `rsp_rdata` holds the enabled lanes of `mem_rdata`, shifted down so that the lowest-addressed byte is bits 7..0. The upper bits are zero.
- R9: Every accepted, non-faulting request drives `mem_en` high for exactly its own cycle, with `mem_we` equal to `req_store`. In all other cycles `mem_en` and `mem_we` are low and `mem_be` is zero.
- R10: `rsp_valid` is high exactly in the cycle after an accepted request (`req_valid` and `req_ready` both high). `rsp_fault` reports that request's fault. `rsp_rdata` is zero for faults, for stores and when no response is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Unit accepts a request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | Addressing form (0 base, 1 base+imm, 2 base+reg) |
| req_size | input | 2 | Access width (0 byte, 1 half, 2 word) |
| req_base | input | 32 | Base register value |
| req_imm | input | 32 | Immediate offset |
| req_offreg | input | 32 | Offset register value |
| req_wdata | input | 32 | Store data, right-justified |
| mem_en | output | 1 | Bus cycle strobe |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read data, one cycle after a read strobe |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 1 | Request faulted |
| rsp_rdata | output | 32 | Zero-extended load result |

## Verification
Directed stores and loads of every width at every lane offset separate correct lane placement from off-by-one-lane and byte-swap errors. Loading back bytes written by stores of a different width shows that little-endian order is kept end to end. Each addressing form is tried with offsets that differ from the base, including a sum that passes 2^32, which separates mode decoding from carry handling. Misaligned halfword and word requests, together with the reserved codes, are each followed by a load of the same bytes, which shows that a fault leaves memory unchanged. A long random mix of widths, offsets, forms and idle cycles in a small window, checked against a byte-level reference memory on every cycle, exposes interactions between back-to-back stores and loads.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned XLEN = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    AM_BASE     = 2'd0,
    AM_BASE_IMM = 2'd1,
    AM_BASE_REG = 2'd2,
    AM_RSVD     = 2'd3
  } addr_mode_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic [1:0]        mode,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] imm,
  input  logic [ADDR_W-1:0] offreg,
  output logic [ADDR_W-1:0] ea,
  output logic              fault
);
  localparam int unsigned OFS_W = $clog2(LANES);

  logic             mode_bad;
  logic             size_bad;
  logic [OFS_W-1:0] amask;
  logic             misal;

  // Effective address; plain addition wraps modulo 2^ADDR_W (R2)
  always_comb begin
    mode_bad = 1'b0;
    case (addr_mode_e'(mode))
      AM_BASE:     ea = base;
      AM_BASE_IMM: ea = base + imm;
      AM_BASE_REG: ea = base + offreg;
      default: begin
        ea       = base;
        mode_bad = 1'b1;
      end
    endcase
  end

  // Largest legal log2(width) equals the lane-offset width (R3)
  assign size_bad = (size > 2'(OFS_W));
  assign amask    = ~({OFS_W{1'b1}} << size);
  assign misal    = |(ea[OFS_W-1:0] & amask);
  assign fault    = mode_bad | size_bad | misal;
endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                        en,
  input  logic [$clog2(DATA_W/8)-1:0] ofs,
  input  logic [1:0]                  size,
  input  logic [DATA_W-1:0]           wdata_in,
  output logic [DATA_W/8-1:0]         be,
  output logic [DATA_W-1:0]           wdata_out
);
  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned OFS_W = $clog2(LANES);
  localparam int unsigned CW    = OFS_W + 3;

  logic [CW-1:0]     lo;
  logic [CW-1:0]     hi;
  logic [DATA_W-1:0] shifted;

  assign lo      = CW'(ofs);
  assign hi      = lo + (CW'(1) << size);
  assign shifted = wdata_in << {ofs, 3'b000};

  // A lane is live when it lies in [ofs, ofs + bytes) (R6, R7)
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[i] = en && (lo <= CW'(i)) && (CW'(i) < hi);
    assign wdata_out[8*i +: 8] = be[i] ? shifted[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                        keep,
  input  logic [$clog2(DATA_W/8)-1:0] ofs,
  input  logic [1:0]                  size,
  input  logic [DATA_W-1:0]           rdata,
  output logic [DATA_W-1:0]           data
);
  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned OFS_W = $clog2(LANES);
  localparam int unsigned CW    = OFS_W + 3;

  logic [DATA_W-1:0] shifted;
  logic [CW-1:0]     nbytes;

  assign shifted = rdata >> {ofs, 3'b000};
  assign nbytes  = CW'(1) << size;

  // Keep the low nbytes lanes only: zero extension (R8)
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign data[8*i +: 8] = (keep && (CW'(i) < nbytes)) ? shifted[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsu_core.sv
module lsu_core
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = XLEN,
  parameter int unsigned DATA_W = XLEN
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_store,
  input  logic [1:0]          req_mode,
  input  logic [1:0]          req_size,
  input  logic [ADDR_W-1:0]   req_base,
  input  logic [ADDR_W-1:0]   req_imm,
  input  logic [ADDR_W-1:0]   req_offreg,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                rsp_valid,
  output logic                rsp_fault,
  output logic [DATA_W-1:0]   rsp_rdata
);
  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned OFS_W = $clog2(LANES);

  logic [ADDR_W-1:0] ea;
  logic              fault;
  logic              accept;
  logic              go;

  // Registered response state
  logic             ready_q,  ready_d;
  logic             rvalid_q, rvalid_d;
  logic             rfault_q, rfault_d;
  logic             rload_q,  rload_d;
  logic [OFS_W-1:0] rofs_q,   rofs_d;
  logic [1:0]       rsize_q,  rsize_d;
  logic             cap_en;

  lsu_agen #(.ADDR_W(ADDR_W), .LANES(LANES)) u_agen (
    .mode   (req_mode),
    .size   (req_size),
    .base   (req_base),
    .imm    (req_imm),
    .offreg (req_offreg),
    .ea     (ea),
    .fault  (fault)
  );

  assign accept = req_valid & ready_q;
  assign go     = accept & ~fault;

  lsu_lane_steer #(.DATA_W(DATA_W)) u_steer (
    .en        (go),
    .ofs       (ea[OFS_W-1:0]),
    .size      (req_size),
    .wdata_in  (req_wdata),
    .be        (mem_be),
    .wdata_out (mem_wdata)
  );

  assign mem_en   = go;
  assign mem_we   = go & req_store;
  assign mem_addr = ea;

  // Next-state logic
  always_comb begin
    ready_d  = 1'b1;
    rvalid_d = accept;
    rfault_d = accept & fault;
    cap_en   = accept;
    rload_d  = rload_q;
    rofs_d   = rofs_q;
    rsize_d  = rsize_q;
    if (cap_en) begin
      rload_d = ~req_store & ~fault;
      rofs_d  = ea[OFS_W-1:0];
      rsize_d = req_size;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      rvalid_q <= 1'b0;
      rfault_q <= 1'b0;
      rload_q  <= 1'b0;
      rofs_q   <= '0;
      rsize_q  <= '0;
    end else begin
      ready_q  <= ready_d;
      rvalid_q <= rvalid_d;
      rfault_q <= rfault_d;
      rload_q  <= rload_d;
      rofs_q   <= rofs_d;
      rsize_q  <= rsize_d;
    end
  end

  lsu_load_align #(.DATA_W(DATA_W)) u_align (
    .keep  (rvalid_q & rload_q),
    .ofs   (rofs_q),
    .size  (rsize_q),
    .rdata (mem_rdata),
    .data  (rsp_rdata)
  );

  assign req_ready = ready_q;
  assign rsp_valid = rvalid_q;
  assign rsp_fault = rfault_q;
endmodule

// File: rtl/lsu_core_chk.sv
module lsu_core_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_store,
  input logic                mem_en,
  input logic                mem_we,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W/8-1:0] mem_be,
  input logic                rsp_valid,
  input logic                rsp_fault,
  input logic [DATA_W-1:0]   rsp_rdata
);
  // R10: one response per accepted request, one cycle later
  p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);
  p_fault_data_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && rsp_rdata == '0));
  // R4/R5: a faulting request produced no bus cycle
  p_fault_no_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> $past(!mem_en));
  // R9: idle bus is quiet; bus cycles only for accepted requests
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en |-> (mem_be == '0 && !mem_we));
  p_bus_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (req_valid && req_ready && (mem_we == req_store)));
  // R6: enable shape matches width and address alignment
  p_be_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));
  p_half_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $countones(mem_be) == 2) |-> (mem_addr[0] == 1'b0));
  p_word_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $countones(mem_be) == 4) |-> (mem_addr[1:0] == 2'b00));
endmodule

bind lsu_core lsu_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_store (req_store),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_rdata (rsp_rdata)
);

// File: tb/lsu_core_bench.sv
module lsu_core_bench;
  logic        clk;
  logic        rst_n;
  logic        req_valid, req_ready, req_store;
  logic [1:0]  req_mode, req_size;
  logic [31:0] req_base, req_imm, req_offreg, req_wdata;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_rdata;

  int total = 0;
  int bad   = 0;

  typedef struct packed {
    logic        fault;
    logic [31:0] data;
  } exp_t;
  exp_t exp_q[$];

  logic [7:0] bus_mem[logic [31:0]];
  logic [7:0] ref_mem[logic [31:0]];

  lsu_core u_lsu_core (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] seed_byte(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] bus_rd(logic [31:0] a);
    return bus_mem.exists(a) ? bus_mem[a] : seed_byte(a);
  endfunction

  function automatic logic [7:0] ref_rd(logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : seed_byte(a);
  endfunction

  // Behavioural single-cycle memory driven by the unit's bus
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) bus_mem[{mem_addr[31:2], 2'(l)}] = mem_wdata[8*l +: 8];
      end else begin
        mem_rdata <= {bus_rd({mem_addr[31:2], 2'd3}), bus_rd({mem_addr[31:2], 2'd2}),
                      bus_rd({mem_addr[31:2], 2'd1}), bus_rd({mem_addr[31:2], 2'd0})};
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, expv, $time);
    end
  endtask

  // One clock of stimulus: check last response, drive, check bus
  task automatic cycle(bit v, bit st, logic [1:0] md, logic [1:0] sz,
                       logic [31:0] b, logic [31:0] im, logic [31:0] rg, logic [31:0] wd);
    logic [31:0] ea;
    bit          flt;
    int          nb;
    logic [3:0]  ebe;
    logic [31:0] ewd;
    logic [31:0] eld;
    exp_t        e;
    @(negedge clk);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      check("R10 rsp_valid", 32'(rsp_valid), 32'd1);
      check("R10 rsp_fault", 32'(rsp_fault), 32'(e.fault));
      check("R8 rsp_rdata", rsp_rdata, e.data);
    end else begin
      check("R10 idle rsp_valid", 32'(rsp_valid), 32'd0);
      check("R10 idle rsp_rdata", rsp_rdata, 32'd0);
    end
    req_valid = v; req_store = st; req_mode = md; req_size = sz;
    req_base = b; req_imm = im; req_offreg = rg; req_wdata = wd;
    case (md)
      2'd0: ea = b;
      2'd1: ea = b + im;
      2'd2: ea = b + rg;
      default: ea = b;
    endcase
    flt = (md == 2'd3) || (sz == 2'd3) || (sz == 2'd1 && ea[0]) || (sz == 2'd2 && ea[1:0] != 2'b00);
    nb  = 1 << sz;
    ebe = '0; ewd = '0; eld = '0;
    if (!flt) begin
      for (int k = 0; k < nb; k++) begin
        ebe[ea[1:0] + 2'(k)] = 1'b1;
        ewd[8*(ea[1:0] + 2'(k)) +: 8] = wd[8*k +: 8];
        eld[8*k +: 8] = ref_rd(ea + 32'(k));
      end
    end
    #1;
    if (v && !flt) begin
      check("R9 mem_en", 32'(mem_en), 32'd1);
      check("R9 mem_we", 32'(mem_we), 32'(st));
      check("R2 mem_addr", mem_addr, ea);
      check("R6 mem_be", 32'(mem_be), 32'(ebe));
      if (st) check("R7 mem_wdata", mem_wdata, ewd);
    end else begin
      check("R4 R5 R9 mem_en idle", 32'(mem_en), 32'd0);
      check("R9 mem_be idle", 32'(mem_be), 32'd0);
      check("R9 mem_we idle", 32'(mem_we), 32'd0);
    end
    if (v) begin
      if (st && !flt)
        for (int k = 0; k < nb; k++) ref_mem[ea + 32'(k)] = wd[8*k +: 8];
      e.fault = flt;
      e.data  = (st || flt) ? 32'd0 : eld;
      exp_q.push_back(e);
    end
  endtask

  task automatic st_(logic [1:0] md, logic [1:0] sz, logic [31:0] b, logic [31:0] im,
                     logic [31:0] rg, logic [31:0] wd);
    cycle(1, 1, md, sz, b, im, rg, wd);
  endtask

  task automatic ld_(logic [1:0] md, logic [1:0] sz, logic [31:0] b, logic [31:0] im,
                     logic [31:0] rg);
    cycle(1, 0, md, sz, b, im, rg, 32'hDEAD_BEEF);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_store = 0; req_mode = 0; req_size = 0;
    req_base = 0; req_imm = 0; req_offreg = 0; req_wdata = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1 mem_en", 32'(mem_en), 32'd0);
    check("R1 mem_be", 32'(mem_be), 32'd0);
    check("R1 req_ready", 32'(req_ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 req_ready after reset", 32'(req_ready), 32'd1);

    // R2: three addressing forms, each storing a word
    st_(2'd0, 2'd2, 32'h100, 32'h0, 32'h0, 32'h4433_2211);
    st_(2'd1, 2'd2, 32'h100, 32'h4, 32'h0, 32'h8877_6655);
    st_(2'd2, 2'd2, 32'h100, 32'h0, 32'h8, 32'hCCBB_AA99);
    ld_(2'd1, 2'd2, 32'h0F0, 32'h10, 32'h0);
    ld_(2'd2, 2'd2, 32'h0F8, 32'h0, 32'h0C);
    // R2: wrap modulo 2^32 lands on 0x4
    st_(2'd1, 2'd2, 32'hFFFF_FFF0, 32'h14, 32'h0, 32'h1234_5678);
    ld_(2'd0, 2'd2, 32'h4, 32'h0, 32'h0);
    // R6 R7 R8: bytes at every lane, read back in several widths
    for (int l = 0; l < 4; l++) st_(2'd1, 2'd0, 32'h110, 32'(l), 32'h0, 32'hF0 + 32'(l));
    for (int l = 0; l < 4; l++) ld_(2'd1, 2'd0, 32'h110, 32'(l), 32'h0);
    ld_(2'd0, 2'd1, 32'h110, 32'h0, 32'h0);
    ld_(2'd0, 2'd1, 32'h112, 32'h0, 32'h0);
    ld_(2'd0, 2'd2, 32'h110, 32'h0, 32'h0);
    // little-endian halfword 0x55AA at 0x120
    st_(2'd0, 2'd1, 32'h120, 32'h0, 32'h0, 32'hFFFF_55AA);
    st_(2'd0, 2'd1, 32'h122, 32'h0, 32'h0, 32'h0000_1357);
    ld_(2'd0, 2'd0, 32'h120, 32'h0, 32'h0);
    ld_(2'd0, 2'd0, 32'h121, 32'h0, 32'h0);
    ld_(2'd0, 2'd2, 32'h120, 32'h0, 32'h0);
    // R4: odd halfword store faults and leaves memory untouched
    st_(2'd0, 2'd1, 32'h121, 32'h0, 32'h0, 32'hAAAA_AAAA);
    ld_(2'd0, 2'd2, 32'h120, 32'h0, 32'h0);
    ld_(2'd2, 2'd1, 32'h122, 32'h0, 32'h1);
    // R5: word at every misaligned offset
    for (int l = 1; l < 4; l++) st_(2'd1, 2'd2, 32'h100, 32'(l), 32'h0, 32'h0BAD_0BAD);
    ld_(2'd0, 2'd2, 32'h100, 32'h0, 32'h0);
    ld_(2'd0, 2'd2, 32'h104, 32'h0, 32'h0);
    // R3 and R2: reserved size and mode codes fault
    st_(2'd0, 2'd3, 32'h100, 32'h0, 32'h0, 32'h0);
    st_(2'd3, 2'd2, 32'h100, 32'h0, 32'h0, 32'h0);
    ld_(2'd0, 2'd2, 32'h100, 32'h0, 32'h0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0);
    cycle(0, 1, 0, 2, 32'h100, 0, 0, 0);

    // Random mix in a small window
    for (int n = 0; n < 600; n++) begin
      logic [1:0]  md = 2'($urandom_range(0, 3));
      logic [1:0]  sz = 2'($urandom_range(0, 3));
      logic [31:0] b  = 32'h200 + 32'($urandom_range(0, 40));
      logic [31:0] im = 32'($urandom_range(0, 15));
      logic [31:0] rg = 32'($urandom_range(0, 15));
      cycle(($urandom_range(0, 4) != 0), $urandom_range(0, 1) == 1, md, sz, b, im, rg,
            $urandom());
    end
    cycle(0, 0, 0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule